// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer Bank

This block holds five independent PWM channels behind a small word-addressed register port. Each channel has a down-counter, an active compare value, and two buffer registers (period and compare) that software may rewrite at any time. Writes to a buffer never reach the running counter directly. New values move into the counter and the active compare only in two cases: while the channel's manual-load bit is held in the shared control word, or when the counter passes its terminal count with auto-reload enabled. A channel whose auto-reload is off runs one last period, then parks with its output idle until software loads it again.

The counter of a channel decrements only on clock cycles where both its tick-enable input and its run bit are high. A prescaler outside the block supplies the tick enables. The raw output of a channel is high while the counter is at or below the active compare value. The all-ones compare value therefore keeps the output high for the whole period. A per-channel inversion bit flips the pin. Inversion comes out of reset enabled on every channel that has one.

The shared control word has an irregular layout, and software must follow it. Channel 0 occupies the lowest 4-bit slot. The next slot (bits 7:4) is unused, so channel n for n ≥ 1 sits in slot n + 1. The last channel has no inversion bit, and its auto-reload bit sits where the other channels keep inversion.

Top module: `pwm_timer_bank`

## Requirements
- R1: Word addresses decode as follows. Word 2 is the control word. Word 3 + 3n is the period buffer of channel n. Word 4 + 3n is the compare buffer of channel n. Reads return the stored values, and every other word reads as zero.
- R2: The control word keeps only its defined bits. Bits 7:4 and bit 23 always read zero, and writing all ones reads back 0x007FFF0F.
- R3: A slot starts at bit 0 for channel 0 and at bit 4(n+1) for channel n ≥ 1. Within a slot, bit 0 is run, bit 1 is manual load, bit 2 is invert and bit 3 is auto-reload. Channel 4 differs: bit 2 of its slot is auto-reload, and it has no invert bit.
- R4: After reset the control word is 0x00044404 (invert set on channels 0 to 3), all buffers and counters are zero, and the outputs are 5'b01111.
- R5: A counter decrements by one on each cycle where its tick enable and run bit are both high. A period buffer value of N gives an output period of N + 1 ticks.
- R6: While manual load is set, the counter and active compare take the buffer values on every clock, counting is paused, and a parked channel is released.
- R7: A buffer write has no effect on the counter or the active compare until the next manual load or auto-reload.
- R8: When a counter is at zero on a tick, the channel behaves according to auto-reload. With auto-reload set, the channel reloads both values from the buffers. With auto-reload clear, the channel parks, and its uninverted output stays low.
- R9: The uninverted output is high exactly when the channel runs, is not parked, and its counter is at or below the active compare. It is low while the run bit is clear.
- R10: An active compare of all ones keeps the uninverted output high for every tick of the period.
- R11: The invert bit flips the channel's output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` (combinational) |
| tick_en | input | 5 | Per-channel count enable |
| pwm_out | output | 5 | PWM output pins, one per channel |

## Verification
Two situations are the hardest to reach from the ports: a buffer write that lands in the middle of a period, and the single edge where a channel at terminal count chooses between reloading and parking. Neither can be seen directly, because the counter is invisible and only the compare result shows on the pin. Directed sequences set the buffers up so that the compare crossing exposes the counter phase. These sequences also flip the compare to all ones in the middle of a period, let a channel without auto-reload run out, and exercise the moved auto-reload bit of the last channel. A long seeded random phase then mixes tick patterns, buffer writes and control writes, with manual loads kept rare. Every cycle of that phase is compared with a bench model of the requirements.

// File: rtl/pwm_timer_pkg.sv
// Package: control-word layout helpers shared by the register file and the bench-facing top.
// Assumes each channel owns a 4-bit slot and slot 1 is left unused.
package pwm_timer_pkg;

    // Lowest bit of a channel's slot in the control word.
    function automatic int slot_lsb(input int ch);
        return (ch == 0) ? 0 : 4 * (ch + 1);
    endfunction

    // Bit position of the auto-reload flag; the odd channel uses slot bit 2.
    function automatic int reload_pos(input int ch, input int odd_ch);
        return slot_lsb(ch) + ((ch == odd_ch) ? 2 : 3);
    endfunction

    // Bits of the control word that hold state.
    function automatic logic [63:0] ctrl_keep_mask(input int nch, input int odd_ch);
        logic [63:0] m;
        m = '0;
        for (int ch = 0; ch < nch; ch++) begin
            m[slot_lsb(ch)]           = 1'b1;
            m[slot_lsb(ch) + 1]       = 1'b1;
            m[reload_pos(ch, odd_ch)] = 1'b1;
            if (ch != odd_ch) m[slot_lsb(ch) + 2] = 1'b1;
        end
        return m;
    endfunction

    // Reset value: invert set on every channel that has an invert bit.
    function automatic logic [63:0] ctrl_reset_value(input int nch, input int odd_ch);
        logic [63:0] v;
        v = '0;
        for (int ch = 0; ch < nch; ch++)
            if (ch != odd_ch) v[slot_lsb(ch) + 2] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Holds the control word and the per-channel period/compare buffers, decodes
// writes, drives combinational read data and splits the control word into
// per-channel flags. Assumes NCH * 3 + 4 words fit in the address space and
// that the control word fits in DW bits.
module pwm_regs #(
    parameter int NCH    = 5,
    parameter int DW     = 32,
    parameter int AW     = 5,
    parameter int ODD_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic [NCH-1:0]           run,
    output logic [NCH-1:0]           manual,
    output logic [NCH-1:0]           invert,
    output logic [NCH-1:0]           reload,
    output logic [NCH-1:0][DW-1:0]   per_buf,
    output logic [NCH-1:0][DW-1:0]   cmp_buf
);
    import pwm_timer_pkg::*;

    localparam int            CW        = 4 * (NCH + 1);
    localparam int            CTRL_WORD = 2;
    localparam logic [CW-1:0] KEEP      = CW'(ctrl_keep_mask(NCH, ODD_CH));
    localparam logic [CW-1:0] RST_VAL   = CW'(ctrl_reset_value(NCH, ODD_CH));

    logic [CW-1:0] ctrl_q;

    // Control word: masked write, reset to invert-on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RST_VAL;
        else if (wr_en && addr == AW'(CTRL_WORD))
            ctrl_q <= wdata[CW-1:0] & KEEP;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_buf
        localparam int PER_WORD = 3 + 3 * ch;
        localparam int CMP_WORD = 4 + 3 * ch;
        localparam int SL       = slot_lsb(ch);
        localparam int RL       = reload_pos(ch, ODD_CH);

        // Period and compare buffers of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                per_buf[ch] <= '0;
                cmp_buf[ch] <= '0;
            end else if (wr_en) begin
                if (addr == AW'(PER_WORD)) per_buf[ch] <= wdata;
                if (addr == AW'(CMP_WORD)) cmp_buf[ch] <= wdata;
            end
        end

        assign run[ch]    = ctrl_q[SL];
        assign manual[ch] = ctrl_q[SL + 1];
        assign reload[ch] = ctrl_q[RL];
        if (ch == ODD_CH) begin : g_noinv
            assign invert[ch] = 1'b0;
        end else begin : g_inv
            assign invert[ch] = ctrl_q[SL + 2];
        end
    end

    // Read mux over all mapped words; unmapped words read zero.
    always_comb begin
        rdata = '0;
        if (addr == AW'(CTRL_WORD)) rdata = DW'(ctrl_q);
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr == AW'(3 + 3 * ch)) rdata = per_buf[ch];
            if (addr == AW'(4 + 3 * ch)) rdata = cmp_buf[ch];
        end
    end

    // R2: the unused slot never reads back as set.
    assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(CTRL_WORD)) |-> (rdata[7:4] == 4'h0));

    // R7: a buffer holds its value across cycles without a write to it.
    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(per_buf) && $stable(cmp_buf)));

endmodule

// File: rtl/pwm_chan.sv
// Module: pwm_chan
// One PWM channel: down-counter, active compare value and park flag, loaded
// from the buffers by manual load or by auto-reload at terminal count.
// Assumes the control flags and buffers come straight from registers.
module pwm_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          manual,
    input  logic          reload,
    input  logic          invert,
    input  logic [DW-1:0] per_buf,
    input  logic [DW-1:0] cmp_buf,
    output logic          pwm_o
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] cmp_q;
    logic          park_q;
    logic          step;
    logic          raw;

    assign step = tick && run && !park_q;

    // Counter, active compare and park flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            park_q <= 1'b0;
        end else if (manual) begin
            cnt_q  <= per_buf;
            cmp_q  <= cmp_buf;
            park_q <= 1'b0;
        end else if (step) begin
            if (cnt_q == '0) begin
                if (reload) begin
                    cnt_q <= per_buf;
                    cmp_q <= cmp_buf;
                end else begin
                    park_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign raw   = run && !park_q && (cnt_q <= cmp_q);
    assign pwm_o = raw ^ invert;

    // R6: manual load copies both buffers.
    assert_manual_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        manual |=> (cnt_q == $past(per_buf) && cmp_q == $past(cmp_buf)));

    // R5: one decrement per enabled tick away from terminal count.
    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: no tick or no run means the counter is frozen.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !(tick && run)) |=> ($stable(cnt_q) && $stable(cmp_q)));

    // R8: auto-reload at terminal count takes the period buffer.
    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && step && cnt_q == '0 && reload) |=> (cnt_q == $past(per_buf)));

    // R8: a parked channel shows its idle level.
    assert_park_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        park_q |-> (pwm_o == invert));

    // R10: all-ones compare keeps the active level while running.
    assert_full_duty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !park_q && cmp_q == '1) |-> (pwm_o != invert));

endmodule

// File: rtl/pwm_timer_bank.sv
// Module: pwm_timer_bank (top)
// Five-channel double-buffered PWM timer with a word-addressed register port.
// Assumes tick_en comes from a prescaler in the same clock domain.
module pwm_timer_bank #(
    parameter int NCH    = 5,
    parameter int DW     = 32,
    parameter int AW     = 5,
    parameter int ODD_CH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [NCH-1:0] tick_en,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0]         run;
    logic [NCH-1:0]         manual;
    logic [NCH-1:0]         invert;
    logic [NCH-1:0]         reload;
    logic [NCH-1:0][DW-1:0] per_buf;
    logic [NCH-1:0][DW-1:0] cmp_buf;

    pwm_regs #(.NCH(NCH), .DW(DW), .AW(AW), .ODD_CH(ODD_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .run     (run),
        .manual  (manual),
        .invert  (invert),
        .reload  (reload),
        .per_buf (per_buf),
        .cmp_buf (cmp_buf)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_en[ch]),
            .run     (run[ch]),
            .manual  (manual[ch]),
            .reload  (reload[ch]),
            .invert  (invert[ch]),
            .per_buf (per_buf[ch]),
            .cmp_buf (cmp_buf[ch]),
            .pwm_o   (pwm_out[ch])
        );
    end

    // R4: the first cycle after reset shows the reset output pattern.
    assert_reset_out_R4: assert property (@(posedge clk)
        $rose(rst_n) |-> (pwm_out == NCH'(pwm_timer_pkg::ctrl_reset_value(NCH, ODD_CH) != 0 ? {NCH{1'b1}} >> 1 : 0)));

endmodule

// File: tb/sim_pwm_timer_bank.sv
// Bench for pwm_timer_bank: directed corner cases, then seeded random
// stimulus compared every cycle against a model built from the requirements.
module sim_pwm_timer_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 5;
    localparam int DW  = 32;
    localparam int AW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [NCH-1:0]  tick = '0;
    wire  [DW-1:0]   rdata;
    wire  [NCH-1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mctrl;
    logic [31:0] mper_b [NCH];
    logic [31:0] mcmp_b [NCH];
    logic [31:0] mcnt   [NCH];
    logic [31:0] mcmp   [NCH];
    bit          mpark  [NCH];

    pwm_timer_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_en(tick), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sbase(input int ch);
        return (ch == 0) ? 0 : 4 * (ch + 1);
    endfunction

    function automatic logic [31:0] cw(input int ch, input bit st, input bit mu, input bit iv, input bit ar);
        logic [31:0] r;
        r = '0;
        r[sbase(ch)]     = st;
        r[sbase(ch) + 1] = mu;
        if (ch != 4) r[sbase(ch) + 2] = iv;
        r[sbase(ch) + ((ch == 4) ? 2 : 3)] = ar;
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_out();
        logic [NCH-1:0] o;
        for (int ch = 0; ch < NCH; ch++) begin
            bit s, iv, raw;
            s   = mctrl[sbase(ch)];
            iv  = (ch != 4) && mctrl[sbase(ch) + 2];
            raw = s && !mpark[ch] && (mcnt[ch] <= mcmp[ch]);
            o[ch] = raw ^ iv;
        end
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock, update the model with the inputs held, compare pins.
    task automatic step();
        @(posedge clk);
        #1;
        if (rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                bit s, mu, ar;
                s  = mctrl[sbase(ch)];
                mu = mctrl[sbase(ch) + 1];
                ar = mctrl[sbase(ch) + ((ch == 4) ? 2 : 3)];
                if (mu) begin
                    mcnt[ch] = mper_b[ch]; mcmp[ch] = mcmp_b[ch]; mpark[ch] = 1'b0;
                end else if (tick[ch] && s && !mpark[ch]) begin
                    if (mcnt[ch] == 0) begin
                        if (ar) begin mcnt[ch] = mper_b[ch]; mcmp[ch] = mcmp_b[ch]; end
                        else mpark[ch] = 1'b1;
                    end else mcnt[ch] = mcnt[ch] - 1;
                end
            end
            if (wr_en) begin
                if (addr == 2) mctrl = wdata & 32'h007F_FF0F;
                for (int ch = 0; ch < NCH; ch++) begin
                    if (addr == AW'(3 + 3 * ch)) mper_b[ch] = wdata;
                    if (addr == AW'(4 + 3 * ch)) mcmp_b[ch] = wdata;
                end
            end
            chk("R9", 32'(pwm_out), 32'(exp_out()));
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        addr = AW'(a);
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic count_high(input int ch, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (pwm_out[ch]) highs++;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int h;
        logic [31:0] manual_bits;
        void'($urandom(32'd20240611));
        mctrl = 32'h0004_4404;
        for (int ch = 0; ch < NCH; ch++) begin
            mper_b[ch] = 0; mcmp_b[ch] = 0; mcnt[ch] = 0; mcmp[ch] = 0; mpark[ch] = 1'b0;
        end
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R4: reset state
        chk("R4", 32'(pwm_out), 32'h0000_000F);
        rd_chk("R4", 2, 32'h0004_4404);
        rd_chk("R4", 3, 32'h0);

        // R1: address map
        for (int ch = 0; ch < NCH; ch++) begin
            wr(3 + 3 * ch, 32'h100 + 32'(ch));
            wr(4 + 3 * ch, 32'h200 + 32'(ch));
        end
        for (int ch = 0; ch < NCH; ch++) begin
            rd_chk("R1", 3 + 3 * ch, 32'h100 + 32'(ch));
            rd_chk("R1", 4 + 3 * ch, 32'h200 + 32'(ch));
        end
        rd_chk("R1", 0, 32'h0);
        rd_chk("R1", 17, 32'h0);

        // R2: kept bits of the control word
        wr(2, 32'hFFFF_FFFF);
        rd_chk("R2", 2, 32'h007F_FF0F);
        wr(2, 32'h0);
        rd_chk("R2", 2, 32'h0);

        // R5: period N+1 with compare 1 gives two high ticks of four
        wr(6, 32'd3);
        wr(7, 32'd1);
        wr(2, cw(1, 0, 1, 0, 0));
        wr(2, cw(1, 1, 0, 0, 1));
        chk("R9", 32'(pwm_out[1]), 32'h0);
        tick = 5'b00010;
        count_high(1, 8, h);
        chk("R5", 32'(h), 32'd4);

        // R7: compare buffer change waits for reload
        wr(7, 32'hFFFF_FFFF);
        chk("R7", 32'(pwm_out[1]), 32'h0);
        repeat (2) step();
        step();
        chk("R7", 32'(pwm_out[1]), 32'h1);
        // R10: all-ones compare is high every tick
        count_high(1, 8, h);
        chk("R10", 32'(h), 32'd8);

        // R11: invert flips the pin
        wr(2, cw(1, 1, 0, 1, 1));
        count_high(1, 4, h);
        chk("R11", 32'(h), 32'd0);

        // R8: no auto-reload parks the channel low
        wr(7, 32'd1);
        wr(2, cw(1, 0, 1, 0, 0));
        wr(2, cw(1, 1, 0, 0, 0));
        repeat (6) step();
        chk("R8", 32'(pwm_out[1]), 32'h0);
        count_high(1, 4, h);
        chk("R8", 32'(h), 32'd0);

        // R6: manual load releases the park and pauses counting
        wr(7, 32'd2);
        wr(2, cw(1, 1, 1, 0, 0));
        repeat (3) step();
        chk("R6", 32'(pwm_out[1]), 32'h0);
        wr(2, cw(1, 1, 0, 0, 0));
        step();
        chk("R6", 32'(pwm_out[1]), 32'h1);

        // R3: channel 4 auto-reload sits in slot bit 2
        tick = 5'b10000;
        wr(15, 32'd1);
        wr(16, 32'd0);
        wr(2, cw(4, 0, 1, 0, 0));
        wr(2, cw(4, 1, 0, 0, 1));
        rd_chk("R3", 2, 32'h0050_0000);
        count_high(4, 6, h);
        chk("R3", 32'(h), 32'd3);

        // Random phase
        manual_bits = '0;
        for (int ch = 0; ch < NCH; ch++) manual_bits |= cw(ch, 0, 1, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            int r, ch;
            tick = NCH'($urandom);
            r  = int'($urandom % 16);
            ch = int'($urandom % NCH);
            if (r < 3)
                wr(3 + 3 * ch, 32'($urandom % 6));
            else if (r < 6)
                wr(4 + 3 * ch, ($urandom % 4 == 0) ? 32'hFFFF_FFFF : 32'($urandom % 8));
            else if (r < 7) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom % 4 != 0) d &= ~manual_bits;
                wr(2, d);
            end else
                step();
        end
        rd_chk("R1", 2, mctrl);

        done = 1'b1;
        finish_run();
    end
endmodule